// File: doc/BRIEF.md
# Nested Interrupt Priority Vector Unit

This unit sits between a set of interrupt sources and a processor core. Each source has a pending flag and a 3-bit priority, with level 0 the most urgent. The unit picks the most urgent pending source that is not blocked and drives a single gated request line while one exists. Software reads a vector word that combines a programmable base address with the winning source index.

When nesting is enabled, reading the vector acknowledges the winner. The unit sets the in-service bit for the winner's priority level. While that bit is set, the unit blocks that level and every less urgent level. Any write to the status register retires one level: the most urgent one that is in service.

There are separate read and write strobes, so a retire and an acknowledge can happen in the same cycle. All widths and counts are parameters, so the unit can be instantiated again for a second interrupt class.

Top module: `nest_prio_vector_unit`

## Requirements
- R1: Among unblocked pending sources, the winner is the one with the smallest priority number. When two sources share a priority, the lower source index wins.
- R2: With nesting enabled, a read of the vector word (read address 1) sets the in-service bit whose number equals the winner's priority. The bit is visible from the next cycle.
- R3: With nesting enabled, a source is blocked when its priority number is greater than or equal to the lowest-numbered in-service bit. `irq_req` is high exactly when at least one pending source is unblocked.
- R4: Any write to the status register (write address 2) clears only the lowest-numbered in-service bit that is set, whatever the write data. For example, 0x09 becomes 0x08 after one write and 0x00 after a second.
- R5: The vector word has the following layout:
  - bits 31:23 read as zero;
  - bits 22:7 hold the 16-bit base register;
  - bits 6:2 hold the winner's source index (index 3 reads as 00011);
  - bits 1:0 read as zero.
  The base register is written at write address 0 from data bits 15:0 and read back at read address 0 in bits 15:0.
- R6: A vector read while no source is pending and unblocked returns index field zero and sets no in-service bit.
- R7: With nesting disabled, vector reads set no in-service bit and no priority masking applies.
- R8: After reset, the in-service status is 0x00 and the base register is 0. A status read (read address 2) returns the status in bits 7:0 and zero in bits 31:8. Read address 3 returns zero.
- R9: When a status write and an acknowledging vector read fall in the same cycle, the unit clears the lowest set bit first and then sets the winner's bit. The winner is chosen from the status held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pend | input | 28 | Pending flag per source |
| src_prio | input | 84 | 3-bit priority per source, source i in bits 3i+2:3i |
| nest_en | input | 1 | Enables nesting, acknowledge and masking |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address: 0 base, 1 vector, 2 status, 3 zero |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 base, 2 status retire |
| wr_data | input | 32 | Write data |
| irq_req | output | 1 | Gated request: an unblocked source is pending |
| svc_status | output | 8 | In-service bit per priority level |

## Verification
An acknowledging vector read and a status retire can land on the same clock edge, and the outcome depends on their order. The bench provokes this directly by holding a lower level in service and then raising a more urgent source while issuing both strobes together. It also mixes both strobes randomly across thousands of cycles. A reference model applies the clear-then-set rule, and the bench compares the resulting status bits, the request line and the following vector read with the model's values.

// File: rtl/npv_pkg.sv
// Package: shared constants and bus register map for the nested priority
// vector unit. Assumes a 32-bit data path and a two-bit word address.
package npv_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_BASE = 2'd0,
        REG_VEC  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } npv_reg_e;
endpackage

// File: rtl/npv_arbiter.sv
// Module: npv_arbiter
// Picks the most urgent pending source that the in-service levels do not
// block. Priority 0 is the most urgent, and ties go to the lower index.
// Assumes that svc_status is registered elsewhere. The module is purely
// combinational; clk and rst_n feed only its assertions.
module npv_arbiter #(
    parameter int NUM_SRC = 28,
    parameter int NUM_LVL = 8,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_pend,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic                      nest_en,
    input  logic [NUM_LVL-1:0]        svc_status,
    output logic                      win_found,
    output logic [IDX_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    localparam int THR_W = $clog2(NUM_LVL + 1);

    logic [THR_W-1:0]   thr;
    logic [NUM_SRC-1:0] elig;

    // Threshold: the lowest-numbered in-service level, or NUM_LVL when none is set.
    always_comb begin
        thr = THR_W'(NUM_LVL);
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (svc_status[l]) thr = THR_W'(l);
        end
    end

    // Per-source eligibility: pending and, when nesting is on, strictly above the threshold.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        logic [PRIO_W-1:0] p;
        assign p = src_prio[i*PRIO_W +: PRIO_W];
        assign elig[i] = src_pend[i] &&
                         (!nest_en || (THR_W'(p) < thr));
    end

    // Winner search: a strict compare keeps the lower index on ties.
    always_comb begin
        win_found = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!win_found ||
                    src_prio[i*PRIO_W +: PRIO_W] < win_prio)) begin
                win_found = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = src_prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // R3: with nesting on, a winner never sits at or below an in-service level.
    a_r3_winner_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
        (win_found && nest_en) |->
            ((svc_status & ((NUM_LVL'(2) << win_prio) - NUM_LVL'(1))) == '0));

    // R6: without a winner, the index is zero.
    a_r6_idle_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !win_found |-> (win_idx == '0));

    // R1: the winner is itself pending.
    a_r1_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        win_found |-> src_pend[win_idx]);
endmodule

// File: rtl/npv_tracker.sv
// Module: npv_tracker
// Holds the in-service level bits. A retire clears the lowest set bit, and
// an acknowledge then sets the bit of the acknowledged level. Both can happen
// on the same edge. Assumes the parent gates ack with nesting enable and a
// valid winner.
module npv_tracker #(
    parameter int NUM_LVL = 8,
    parameter int PRIO_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               retire,
    input  logic               ack,
    input  logic [PRIO_W-1:0]  ack_prio,
    output logic [NUM_LVL-1:0] svc_status
);
    logic [NUM_LVL-1:0] low_bit;
    logic [NUM_LVL-1:0] set_bit;
    logic [NUM_LVL-1:0] nxt;

    // Next state: clear first, then set.
    always_comb begin
        low_bit = svc_status & (~svc_status + NUM_LVL'(1));
        set_bit = ack ? (NUM_LVL'(1) << ack_prio) : '0;
        nxt     = (retire ? (svc_status & ~low_bit) : svc_status) | set_bit;
    end

    // Status register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) svc_status <= '0;
        else        svc_status <= nxt;
    end

    // R8: reset leaves no level in service.
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (svc_status == '0));

    // R4: a lone retire removes exactly one bit when any bit is set.
    a_r4_one_bit_retired: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !ack && svc_status != '0) |=>
            ($countones(svc_status) == $countones($past(svc_status)) - 1));

    // R2: an acknowledge marks its level in service.
    a_r2_ack_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> svc_status[$past(ack_prio)]);

    // R7/R6: without an acknowledge, no new bit appears.
    a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> ((svc_status & ~$past(svc_status)) == '0));
endmodule

// File: rtl/npv_regfile.sv
// Module: npv_regfile
// Holds the base register and forms the read data for the base, vector and
// status addresses. Assumes win_idx is already zero when no source wins.
module npv_regfile
    import npv_pkg::*;
#(
    parameter int NUM_LVL = 8,
    parameter int IDX_W   = 5,
    parameter int BASE_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [NUM_LVL-1:0] svc_status
);
    localparam int PAD_W = DATA_W - BASE_W - IDX_W - 2;

    logic [BASE_W-1:0] base_q;
    wire unused_wdata = ^wr_data[DATA_W-1:BASE_W];

    // Base register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                               base_q <= '0;
        else if (wr_en && wr_addr == REG_BASE)    base_q <= wr_data[BASE_W-1:0];
    end

    // Read mux: the vector word packs the base above the index field.
    always_comb begin
        case (npv_reg_e'(rd_addr))
            REG_BASE: rd_data = {{(DATA_W-BASE_W){1'b0}}, base_q};
            REG_VEC:  rd_data = {{PAD_W{1'b0}}, base_q, win_idx, 2'b00};
            REG_STAT: rd_data = {{(DATA_W-NUM_LVL){1'b0}}, svc_status};
            default:  rd_data = '0;
        endcase
    end

    // R5: the vector word keeps its zero fields.
    a_r5_vector_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == REG_VEC) |->
            (rd_data[1:0] == 2'b00 && rd_data[DATA_W-1:DATA_W-PAD_W] == '0));

    // R8: the status read has zero upper bits.
    a_r8_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == REG_STAT) |-> (rd_data[DATA_W-1:NUM_LVL] == '0));
endmodule

// File: rtl/nest_prio_vector_unit.sv
// Module: nest_prio_vector_unit
// Top of the nested interrupt priority vector unit. It combines the winner
// search, the in-service tracker and the register file. A vector read
// acknowledges only when nesting is on and a winner exists. Any write to the
// status address retires a level. Assumes a single clock domain with
// synchronous inputs.
module nest_prio_vector_unit
    import npv_pkg::*;
#(
    parameter int NUM_SRC = 28,
    parameter int NUM_LVL = 8,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = 5,
    parameter int BASE_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_pend,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic                      nest_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic                      irq_req,
    output logic [NUM_LVL-1:0]        svc_status
);
    logic              win_found;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_prio;
    logic              ack;
    logic              retire;

    // Strobe decode for acknowledge and retire.
    always_comb begin
        ack     = rd_en && (rd_addr == REG_VEC) && nest_en && win_found;
        retire  = wr_en && (wr_addr == REG_STAT);
        irq_req = win_found;
    end

    npv_arbiter #(
        .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
    ) u_arb (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_prio(src_prio),
        .nest_en(nest_en), .svc_status(svc_status),
        .win_found(win_found), .win_idx(win_idx), .win_prio(win_prio)
    );

    npv_tracker #(
        .NUM_LVL(NUM_LVL), .PRIO_W(PRIO_W)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .retire(retire), .ack(ack),
        .ack_prio(win_prio), .svc_status(svc_status)
    );

    npv_regfile #(
        .NUM_LVL(NUM_LVL), .IDX_W(IDX_W), .BASE_W(BASE_W)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .win_idx(win_idx), .svc_status(svc_status)
    );

    // R7: with nesting off, any pending source raises the request.
    a_r7_no_mask_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_en && src_pend != '0) |-> irq_req);

    // R9: a combined retire and acknowledge keeps the acknowledged level set.
    a_r9_set_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && retire) |=> svc_status[$past(win_prio)]);
endmodule

// File: tb/test_nest_prio_vector_unit.sv
module test_nest_prio_vector_unit;
    localparam int NS = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0]   src_pend = '0;
    logic [NS*3-1:0] src_prio = '0;
    logic        nest_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        irq_req;
    logic [7:0]  svc_status;

    logic [2:0]  prio_a [NS];
    logic [7:0]  m_stat = '0;
    logic [15:0] m_base = '0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nest_prio_vector_unit i_nest_prio_vector_unit (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_prio(src_prio),
        .nest_en(nest_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_req(irq_req), .svc_status(svc_status)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic int m_thr(logic [7:0] s);
        int t = 8;
        for (int l = 7; l >= 0; l--) if (s[l]) t = l;
        return t;
    endfunction

    // Reference winner from the requirements (R1, R3, R7).
    function automatic void m_win(output bit found, output int idx, output int pr);
        int t = m_thr(m_stat);
        found = 0; idx = 0; pr = 0;
        for (int i = 0; i < NS; i++) begin
            if (src_pend[i] && (!nest_en || int'(prio_a[i]) < t) &&
                    (!found || int'(prio_a[i]) < pr)) begin
                found = 1; idx = i; pr = int'(prio_a[i]);
            end
        end
    endfunction

    function automatic logic [31:0] m_rd(logic [1:0] a);
        bit f; int idx; int pr;
        m_win(f, idx, pr);
        case (a)
            2'd0: return {16'h0, m_base};
            2'd1: return {9'h0, m_base, 5'(idx), 2'b00};
            2'd2: return {24'h0, m_stat};
            default: return 32'h0;
        endcase
    endfunction

    task automatic pack_prio();
        for (int i = 0; i < NS; i++) src_prio[i*3 +: 3] = prio_a[i];
    endtask

    // One cycle: inputs are already set after a falling edge. Check the
    // outputs, then advance the model at the rising edge.
    task automatic cyc(string tag);
        bit f; int idx; int pr;
        logic [7:0] low;
        pack_prio();
        #1;
        m_win(f, idx, pr);
        chk({tag, " R3 irq_req"}, {31'h0, irq_req}, {31'h0, f});
        chk({tag, " R8 status"}, {24'h0, svc_status}, {24'h0, m_stat});
        if (rd_en) chk({tag, " R5 rd_data"}, rd_data, m_rd(rd_addr));
        @(posedge clk);
        low = m_stat & (~m_stat + 8'd1);
        if (wr_en && wr_addr == 2'd2) m_stat = m_stat & ~low;
        if (rd_en && rd_addr == 2'd1 && nest_en && f) m_stat[pr] = 1'b1;
        if (wr_en && wr_addr == 2'd0) m_base = wr_data[15:0];
        @(negedge clk);
        rd_en = 0; wr_en = 0;
    endtask

    task automatic rd_vec(); rd_en = 1; rd_addr = 2'd1; endtask
    task automatic wr_stat(logic [31:0] d); wr_en = 1; wr_addr = 2'd2; wr_data = d; endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NS; i++) prio_a[i] = 3'd7;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R8: reset state.
        chk("R8 reset status", {24'h0, svc_status}, 32'h0);
        rd_en = 1; rd_addr = 2'd0; #1;
        chk("R8 reset base", rd_data, 32'h0);
        rd_addr = 2'd3; #1;
        chk("R8 unused address", rd_data, 32'h0);
        cyc("R8");
        // R5: base write and readback, upper data ignored.
        wr_en = 1; wr_addr = 2'd0; wr_data = 32'hFFFF_ABCD; cyc("R5");
        rd_en = 1; rd_addr = 2'd0; #1;
        chk("R5 base readback", rd_data, 32'h0000_ABCD);
        cyc("R5");
        // R2/R5: source 3 at priority 3.
        nest_en = 1; prio_a[3] = 3'd3; src_pend = 28'h8; pack_prio(); rd_vec(); #1;
        chk("R5 vector word", rd_data, {9'h0, 16'hABCD, 5'b00011, 2'b00});
        cyc("R2");
        chk("R2 level 3 set", {24'h0, svc_status}, 32'h08);
        chk("R3 level 3 blocked", {31'h0, irq_req}, 32'h0);
        // R3/R2: source 7 at priority 0 nests.
        prio_a[7] = 3'd0; src_pend = 28'h88; pack_prio(); #1;
        chk("R3 higher level passes", {31'h0, irq_req}, 32'h1);
        rd_vec(); #1;
        chk("R1 vector index 7", {27'h0, rd_data[6:2]}, 32'd7);
        cyc("R2");
        chk("R2 status 0x09", {24'h0, svc_status}, 32'h09);
        // R4: two retires, data ignored.
        wr_stat(32'h0); cyc("R4");
        chk("R4 first retire", {24'h0, svc_status}, 32'h08);
        wr_stat(32'hFF); cyc("R4");
        chk("R4 second retire", {24'h0, svc_status}, 32'h00);
        // R1: tie at priority 2 between sources 9 and 5.
        src_pend = '0; prio_a[5] = 3'd2; prio_a[9] = 3'd2; src_pend[5] = 1; src_pend[9] = 1;
        pack_prio(); rd_vec(); #1;
        chk("R1 tie lower index", {27'h0, rd_data[6:2]}, 32'd5);
        cyc("R1");
        chk("R2 level 2 set", {24'h0, svc_status}, 32'h04);
        // R6: vector read with nothing unblocked.
        rd_vec(); #1;
        chk("R6 idle index", {27'h0, rd_data[6:2]}, 32'd0);
        cyc("R6");
        chk("R6 no set", {24'h0, svc_status}, 32'h04);
        // R9: retire level 2 and acknowledge priority 1 on the same edge.
        prio_a[11] = 3'd1; src_pend = '0; src_pend[11] = 1; pack_prio();
        rd_vec(); wr_stat(32'h5A); cyc("R9");
        chk("R9 clear then set", {24'h0, svc_status}, 32'h02);
        // R7: nesting off, no masking and no set.
        nest_en = 0; src_pend = '0; src_pend[3] = 1; pack_prio(); #1;
        chk("R7 no masking", {31'h0, irq_req}, 32'h1);
        rd_vec(); cyc("R7");
        chk("R7 no set", {24'h0, svc_status}, 32'h02);
        nest_en = 1; wr_stat(32'h0); cyc("R4");
        // Random phase (R1, R2, R3, R4, R9).
        for (int n = 0; n < 4000; n++) begin
            if (n % 64 == 0)
                for (int i = 0; i < NS; i++) prio_a[i] = 3'($urandom_range(0, 7));
            if (n % 700 == 350) nest_en = ~nest_en;
            for (int i = 0; i < NS; i++) src_pend[i] = ($urandom_range(0, 9) == 0);
            rd_en = ($urandom_range(0, 9) < 4);
            rd_addr = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd1;
            wr_en = ($urandom_range(0, 9) < 2);
            wr_addr = ($urandom_range(0, 7) == 0) ? 2'd0 : 2'd2;
            wr_data = $urandom;
            cyc("R9 random");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule